// File: doc/BRIEF.md
# Modem Status Change Tracker

This block is the modem status register of a serial controller. It watches three active-low modem handshake pins: clear-to-send, data-set-ready and carrier-detect. Each pin first passes through a two-flop synchronizer. The block then reports the true, active-high state of each line in the upper half of an 8-bit status byte.

Next to each level bit it keeps a sticky change flag in the lower half. A flag is set by any toggle of its synchronized line and stays set until the register is read. A read is signalled by a one-cycle strobe. The status byte seen during the strobe cycle is the value returned, and the flags are cleared at the following clock edge. A toggle that arrives in that same cycle survives the clear, so no change is lost.

A registered interrupt request is raised whenever modem-status interrupts are enabled and at least one flag is set. The clear-to-send level is status only and drives nothing else. The enable input corresponds to bit 3 of the controller's interrupt enable register.

Top module: `modem_status_tracker`

## Requirements
- R1: Status bits 4, 5 and 7 read 1 when the clear-to-send, data-set-ready and carrier-detect pin (respectively) is low, and 0 when it is high. A pin change becomes visible on the second rising clock edge after it is applied.
- R2: Status bits 0, 1 and 3 are change flags for clear-to-send, data-set-ready and carrier-detect (respectively). A flag is set on the third rising edge after its pin toggles, and it stays set while no read strobe is given.
- R3: When `rd_stb` is high in a cycle, the flags are cleared at the next rising edge. The exception is a flag whose line changes in that same cycle, which stays set.
- R4: `irq_o` is set at the same edge as `status_o` when `msi_en` is high and at least one change flag is set at that edge.
- R5: `irq_o` is low after any edge at which `msi_en` was low, or at which all change flags became clear.
- R6: Status bits 2 and 6 always read 0.
- R7: A synchronous master reset (`rst` high at a rising edge) has the following effects:
  - It clears all change flags and `irq_o`.
  - It treats every pin as high (inactive), so the level bits read 0.
  - No flag is raised afterwards while the pins stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| rd_stb | input | 1 | One-cycle strobe marking a read of the status register |
| msi_en | input | 1 | Modem-status interrupt enable |
| status_o | output | 8 | Status byte: levels in bits 7, 5, 4; change flags in bits 3, 1, 0 |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- a flag never drops without a read;
- a read with no coincident toggle empties the flags;
- a detected toggle always leaves a flag set;
- the interrupt never stands without a flag;
- the interrupt never follows a cycle with the enable low;
- reset empties everything.

The exact latency of the synchronizer and the mapping of each pin to its bit positions can only be shown by the bench scenarios. The same holds for the survival of a flag whose toggle lands in the read cycle. The bench shows these by comparing the status byte against a cycle model driven from the pin sequence.

// File: rtl/mst_pkg.sv
package mst_pkg;
  localparam int unsigned LINES = 3;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned SYNC_STAGES = 2;
  // line index order inside internal vectors
  localparam int unsigned L_CTS = 0;
  localparam int unsigned L_DSR = 1;
  localparam int unsigned L_DCD = 2;
  // status bit positions (software-visible, fixed)
  localparam int unsigned B_DCTS = 0;
  localparam int unsigned B_DDSR = 1;
  localparam int unsigned B_DDCD = 3;
  localparam int unsigned B_CTS  = 4;
  localparam int unsigned B_DSR  = 5;
  localparam int unsigned B_DCD  = 7;
  typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/mst_sync.sv
module mst_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= RST_VAL;
    else     chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= RST_VAL;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mst_delta.sv
module mst_delta #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] line_i,
  input  logic             rd_stb,
  input  logic             msi_en,
  output logic [WIDTH-1:0] delta_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] prev_q, delta_q, delta_d, change;
  logic             irq_q;

  assign change  = line_i ^ prev_q;
  assign delta_d = (rd_stb ? '0 : delta_q) | change;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= RST_VAL;
      delta_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      prev_q  <= line_i;
      delta_q <= delta_d;
      irq_q   <= msi_en && (|delta_d);
    end
  end

  assign delta_o = delta_q;
  assign irq_o   = irq_q;

  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
  assert_change_flags_R2: assert property (@(posedge clk) disable iff (rst)
    (|change) |=> (|delta_q));
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && change == '0) |=> (delta_q == '0));
  assert_irq_has_flag_R4: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (|delta_q));
  assert_irq_drop_R5: assert property (@(posedge clk) disable iff (rst)
    !msi_en |=> !irq_q);
  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (delta_q == '0 && !irq_q));
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
  import mst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       dcd_n,
  input  logic       rd_stb,
  input  logic       msi_en,
  output logic [7:0] status_o,
  output logic       irq_o
);
  line_vec_t pins_n, sync_n, delta;

  assign pins_n[L_CTS] = cts_n;
  assign pins_n[L_DSR] = dsr_n;
  assign pins_n[L_DCD] = dcd_n;

  mst_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d_i(pins_n), .q_o(sync_n)
  );

  mst_delta #(.WIDTH(LINES), .RST_VAL('1)) u_delta (
    .clk(clk), .rst(rst), .line_i(sync_n), .rd_stb(rd_stb),
    .msi_en(msi_en), .delta_o(delta), .irq_o(irq_o)
  );

  always_comb begin
    status_o         = '0;
    status_o[B_DCTS] = delta[L_CTS];
    status_o[B_DDSR] = delta[L_DSR];
    status_o[B_DDCD] = delta[L_DCD];
    status_o[B_CTS]  = ~sync_n[L_CTS];
    status_o[B_DSR]  = ~sync_n[L_DSR];
    status_o[B_DCD]  = ~sync_n[L_DCD];
  end

  assert_spare_bits_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (status_o[2] == 1'b0 && status_o[6] == 1'b0 && (status_o[3:0] != 4'd0)));
endmodule

// File: tb/modem_status_tracker_test.sv
module modem_status_tracker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cts_n = 1'b1, dsr_n = 1'b1, dcd_n = 1'b1;
  logic rd_stb = 1'b0, msi_en = 1'b0;
  logic [7:0] status_o;
  logic irq_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  modem_status_tracker uut (
    .clk(clk), .rst(rst), .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n),
    .rd_stb(rd_stb), .msi_en(msi_en), .status_o(status_o), .irq_o(irq_o)
  );

  // cycle model built from R1-style timing: two sync edges, third edge for flags
  logic [2:0] m1 = 3'b111, m2 = 3'b111, mp = 3'b111, md = 3'b000;
  logic mi = 1'b0;
  always @(posedge clk) begin
    logic [2:0] nd;
    if (rst) begin
      m1 = 3'b111; m2 = 3'b111; mp = 3'b111; md = 3'b000; mi = 1'b0;
    end else begin
      nd = (rd_stb ? 3'b000 : md) | (m2 ^ mp);
      mi = msi_en && (nd != 3'b000);
      md = nd; mp = m2; m2 = m1; m1 = {dcd_n, dsr_n, cts_n};
    end
  end

  function automatic logic [7:0] exp_status(input logic [2:0] lv_n, input logic [2:0] d);
    return {~lv_n[2], 1'b0, ~lv_n[1], ~lv_n[0], d[2], 1'b0, d[1], d[0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_checks();
    logic [7:0] e;
    e = exp_status(m2, md);
    check("R1 level bits", {29'd0, status_o[7], status_o[5], status_o[4]},
          {29'd0, e[7], e[5], e[4]});
    check("R2 R3 change flags", {29'd0, status_o[3], status_o[1], status_o[0]},
          {29'd0, e[3], e[1], e[0]});
    check("R6 spare bits", {30'd0, status_o[6], status_o[2]}, 32'd0);
    check("R4 R5 irq", {31'd0, irq_o}, {31'd0, mi});
  endtask

  task automatic step(input logic [2:0] pins, input logic rd, input logic en);
    @(negedge clk);
    model_checks();
    {dcd_n, dsr_n, cts_n} = pins;
    rd_stb = rd;
    msi_en = en;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    check("R7 reset status", {24'd0, status_o}, 32'd0);
    check("R7 reset irq", {31'd0, irq_o}, 32'd0);
    repeat (4) step(3'b111, 1'b0, 1'b1);
    check("R7 quiet after reset", {24'd0, status_o}, 32'd0);

    // R1/R2: drop CTS only, observe latency directly
    step(3'b110, 1'b0, 1'b1);   // applied before edge k
    @(negedge clk);             // after edge k
    check("R1 not yet visible", {31'd0, status_o[4]}, 32'd0);
    @(negedge clk);             // after edge k+1
    check("R1 CTS level visible", {31'd0, status_o[4]}, 32'd1);
    check("R2 flag not yet", {31'd0, status_o[0]}, 32'd0);
    @(negedge clk);             // after edge k+2
    check("R2 CTS flag set", {24'd0, status_o}, 32'h11);
    check("R4 irq with flag", {31'd0, irq_o}, 32'd1);

    // R5: enable removed
    msi_en = 1'b0;
    @(negedge clk);
    check("R5 irq off when disabled", {31'd0, irq_o}, 32'd0);
    check("R2 flag sticky", {31'd0, status_o[0]}, 32'd1);

    // R3: read clears
    rd_stb = 1'b1; msi_en = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check("R3 read clears flags", {28'd0, status_o[3:0]}, 32'd0);
    check("R5 irq off after clear", {31'd0, irq_o}, 32'd0);

    // R3: DCD change coincides with the read cycle
    dcd_n = 1'b0;               // before edge k
    @(negedge clk);             // after k
    @(negedge clk);             // after k+1: change in flight this cycle
    rd_stb = 1'b1;
    @(negedge clk);             // after k+2
    rd_stb = 1'b0;
    check("R3 coincident change kept", {28'd0, status_o[3:0]}, 32'd8);
    check("R1 DCD level", {31'd0, status_o[7]}, 32'd1);

    // R7: mid-run reset
    rst = 1'b1;
    @(negedge clk);
    check("R7 mid reset flags", {28'd0, status_o[3:0]}, 32'd0);
    check("R7 mid reset irq", {31'd0, irq_o}, 32'd0);
    {dcd_n, dsr_n, cts_n} = 3'b111;
    @(negedge clk);
    rst = 1'b0;

    // random phase against the cycle model
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] p;
      p = {dcd_n, dsr_n, cts_n};
      if ($urandom_range(0, 3) == 0) p = 3'($urandom);
      step(p, ($urandom_range(0, 4) == 0), ($urandom_range(0, 7) != 0));
    end
    step(3'b111, 1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule